// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Datapath

This block is a 32-bit integer datapath split into five stages: fetch, decode with register read, execute, memory access and write-back. It runs a small load/store subset: four register-register logic and arithmetic operations plus a signed set-less-than, an add-immediate, a word load and a word store. Instruction memory, data memory and a 32-entry register file live inside the block. While reset is held, an external write port preloads them, and a read-back port lets the surrounding logic inspect registers and data words at any time.

Every pipeline register carries the complete instruction word. The register-write destination is selected at the very end of the pipe, by decoding the copy of the word held between memory access and write-back. There is no hazard detection, no forwarding, no stall and no branch logic. A consumer placed one or two slots behind its producer therefore sees the older register value, and software must space dependent instructions itself. A five-slot occupancy output shows, for every cycle, which instruction word sits in each stage and whether that slot holds a real instruction or a bubble.

Top module: `pipe5_core`

## Requirements
- R1: While rst_n is low at a rising edge, every pipeline register is cleared to an all-zero instruction word with its valid flag low and the program counter becomes 0. During reset all five `stage_vld` bits are 0.
- R2: Out of reset, the program counter advances by 4 at every rising edge and each instruction moves one stage per cycle. Slot s of `stage_ir` (bits 32*s+31:32*s, with s=0 fetch, 1 decode, 2 execute, 3 memory, 4 write-back) shows the word fetched s cycles earlier, and `stage_vld[s]` is set once a real instruction has reached that stage.
- R3: Opcode field [31:26]=0 selects a register operation from funct [5:0]: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed less-than giving 1 or 0. Each reads rs [25:21] and rt [20:16] and writes rd [15:11].
- R4: Opcode 0x08 writes rs plus the sign-extended 16-bit immediate [15:0] into rt.
- R5: Opcode 0x23 loads, and opcode 0x2B stores, the data word at byte address rs plus the sign-extended immediate. The word index is address bits [7:2] with the default depth, so address bits 1:0 and the bits above the depth are ignored. A load writes rt. A store writes no register.
- R6: Register 0 always reads as zero. Writes to it from the pipeline or from the load port are discarded.
- R7: A register written in write-back is visible to the instruction in decode in that same cycle. There is no forwarding, so the instructions one and two slots behind a producer read the old value.
- R8: Any other opcode, and any unlisted funct under opcode 0, writes no register and no data word.
- R9: Load port: with load_en high, load_sel 0 writes instruction word load_addr, 1 writes data word load_addr, and 2 writes register load_addr[4:0]. The peek port returns register peek_addr[4:0] when peek_sel is 0 and data word peek_addr when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Preload write strobe |
| load_sel | input | 2 | Preload target: 0 instruction, 1 data, 2 register |
| load_addr | input | LOAD_AW | Preload word or register index |
| load_data | input | 32 | Preload value |
| peek_sel | input | 1 | Read-back source: 0 register, 1 data word |
| peek_addr | input | LOAD_AW | Read-back index |
| peek_data | output | 32 | Read-back value |
| stage_vld | output | 5 | Per-stage valid flags, bit 0 fetch |
| stage_ir | output | 160 | Per-stage instruction words, slot 0 fetch |

## Verification
The hardest situation to reach from the ports is the exact visibility window of a register write. With no forwarding, the outcome depends on how many slots separate producer and consumer. The bench preloads a known old value and places an add-immediate ahead of three consumers at distances one, two and three. It then reads back two stale copies and one fresh copy. A similar chain puts a store ahead of a load of the same word, and a write to register 0 ahead of a consumer that would expose it.

// File: rtl/pipe5_pkg.sv
// pipe5_pkg: shared constants, instruction field helpers and pipeline
// register layouts for the five-stage datapath.
// Assumes a fixed 32-bit instruction word with opcode in [31:26].
package pipe5_pkg;

    localparam int XLEN   = 32;
    localparam int NSTAGE = 5;
    localparam int NREG   = 32;
    localparam int RIDX_W = 5;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_LOAD = 6'h23;
    localparam logic [5:0] OPC_STOR = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    localparam logic [1:0] TGT_IMEM = 2'd0;
    localparam logic [1:0] TGT_DMEM = 2'd1;
    localparam logic [1:0] TGT_REGS = 2'd2;

    typedef enum logic [2:0] {
        ALU_NONE,
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_fn_e;

    // Decode-to-execute register: word plus the two operands read in decode.
    typedef struct packed {
        logic  vld;
        word_t ir;
        word_t opa;
        word_t opb;
    } idex_t;

    // Execute-to-memory register: ALU result and the store data.
    typedef struct packed {
        logic  vld;
        word_t ir;
        word_t res;
        word_t sdata;
    } exmem_t;

    // Memory-to-write-back register: ALU result and the loaded word.
    typedef struct packed {
        logic  vld;
        word_t ir;
        word_t res;
        word_t ldata;
    } memwb_t;

    function automatic logic [5:0] f_opc(input word_t w);
        return w[31:26];
    endfunction

    function automatic word_t f_sext16(input logic [15:0] imm);
        return {{16{imm[15]}}, imm};
    endfunction

endpackage

// File: rtl/pipe5_regfile.sv
// pipe5_regfile: 32-entry register file with one write port and three
// read ports (two for decode, one for read-back).
// Assumes the write happens at the rising edge and a same-cycle read of
// the written index returns the new value (write-before-read). Index 0
// reads as zero and is never stored.
module pipe5_regfile
    import pipe5_pkg::*;
#(
    parameter int NENT = NREG
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  ridx_t wr_idx,
    input  word_t wr_val,
    input  ridx_t rd_idx_a,
    output word_t rd_val_a,
    input  ridx_t rd_idx_b,
    output word_t rd_val_b,
    input  ridx_t rd_idx_c,
    output word_t rd_val_c
);

    word_t cells [NENT];

    // Store a write unless it targets the hard-wired zero register.
    always_ff @(posedge clk) begin
        if (wr_en && wr_idx != '0) begin
            cells[wr_idx] <= wr_val;
        end
    end

    // Read with zero-register masking and same-cycle write pass-through.
    function automatic word_t rd_port(input ridx_t idx, input logic we,
                                      input ridx_t widx, input word_t wval,
                                      input word_t stored);
        if (idx == '0)                 return '0;
        else if (we && widx == idx)    return wval;
        else                           return stored;
    endfunction

    always_comb begin
        rd_val_a = rd_port(rd_idx_a, wr_en, wr_idx, wr_val, cells[rd_idx_a]);
        rd_val_b = rd_port(rd_idx_b, wr_en, wr_idx, wr_val, cells[rd_idx_b]);
        rd_val_c = rd_port(rd_idx_c, wr_en, wr_idx, wr_val, cells[rd_idx_c]);
    end

    // R9: a write to a nonzero register is what that register holds next cycle
    // R9
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != '0) |=> (cells[$past(wr_idx)] == $past(wr_val)));

    // R6
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == '0 && rd_idx_c == '0) |-> (rd_val_c == '0));

endmodule

// File: rtl/pipe5_alu.sv
// pipe5_alu: execute-stage arithmetic. Decodes the instruction word held in
// the decode-to-execute register and produces one result: a register-
// register operation, or base plus sign-extended immediate for the
// immediate add and the memory ops. Unsupported words give zero.
module pipe5_alu
    import pipe5_pkg::*;
(
    input  logic [5:0]  opc,
    input  logic [5:0]  funct,
    input  logic [15:0] imm,
    input  word_t       opa,
    input  word_t       opb,
    output word_t       res
);

    alu_fn_e fn;
    word_t   rhs;

    // Pick the operation and the right-hand operand from the word.
    always_comb begin
        fn  = ALU_NONE;
        rhs = opb;
        unique case (opc)
            OPC_REG: begin
                unique case (funct)
                    FN_ADD:  fn = ALU_ADD;
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    FN_SLT:  fn = ALU_SLT;
                    default: fn = ALU_NONE;
                endcase
            end
            OPC_ADDI, OPC_LOAD, OPC_STOR: begin
                fn  = ALU_ADD;
                rhs = f_sext16(imm);
            end
            default: fn = ALU_NONE;
        endcase
    end

    // Single shared arithmetic unit.
    always_comb begin
        unique case (fn)
            ALU_ADD: res = opa + rhs;
            ALU_SUB: res = opa - rhs;
            ALU_AND: res = opa & rhs;
            ALU_OR:  res = opa | rhs;
            ALU_SLT: res = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(rhs))};
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/pipe5_wbsel.sv
// pipe5_wbsel: write-back control. Decodes the instruction copy in the
// memory-to-write-back register and chooses the destination field (rd for
// register ops, rt for immediate add and loads), the write enable and
// whether the loaded word or the ALU result is written.
module pipe5_wbsel
    import pipe5_pkg::*;
(
    input  logic [5:0] opc,
    input  logic [5:0] funct,
    input  ridx_t      f_rt,
    input  ridx_t      f_rd,
    output logic       we,
    output ridx_t      dest,
    output logic       from_mem
);

    // Destination multiplexer driven by instruction type.
    always_comb begin
        we       = 1'b0;
        dest     = f_rd;
        from_mem = 1'b0;
        unique case (opc)
            OPC_REG: begin
                dest = f_rd;
                we   = (funct == FN_ADD) || (funct == FN_SUB) ||
                       (funct == FN_AND) || (funct == FN_OR)  ||
                       (funct == FN_SLT);
            end
            OPC_ADDI: begin
                dest = f_rt;
                we   = 1'b1;
            end
            OPC_LOAD: begin
                dest     = f_rt;
                we       = 1'b1;
                from_mem = 1'b1;
            end
            default: we = 1'b0;
        endcase
    end

endmodule

// File: rtl/pipe5_core.sv
// pipe5_core: five-stage in-order datapath (fetch, decode, execute, memory,
// write-back) with internal instruction memory, data memory and register
// file. Assumes preloading happens while rst_n is low; no hazard, forward,
// stall or branch logic exists, so software spaces dependent instructions.
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6,
    parameter int LOAD_AW = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_en,
    input  logic [1:0]             load_sel,
    input  logic [LOAD_AW-1:0]     load_addr,
    input  logic [31:0]            load_data,
    input  logic                   peek_sel,
    input  logic [LOAD_AW-1:0]     peek_addr,
    output logic [31:0]            peek_data,
    output logic [NSTAGE-1:0]      stage_vld,
    output logic [NSTAGE*XLEN-1:0] stage_ir
);

    localparam int IMEM_DEPTH = 1 << IMEM_AW;
    localparam int DMEM_DEPTH = 1 << DMEM_AW;

    word_t imem [IMEM_DEPTH];
    word_t dmem [DMEM_DEPTH];

    word_t  pc_q;
    word_t  fetch_ir;
    logic   ifid_vld;
    word_t  ifid_ir;
    idex_t  idex_q;
    exmem_t exmem_q;
    memwb_t memwb_q;

    word_t rs_val, rt_val, alu_res, mem_rd, wb_val;
    logic  wb_we, wb_from_mem, rf_we;
    ridx_t wb_dest, rf_widx;
    word_t rf_wval, peek_reg;

    // ---------------- fetch ----------------
    // Program counter: cleared in reset, one word forward every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_q + 32'd4;
    end

    // Instruction memory preload port.
    always_ff @(posedge clk) begin
        if (load_en && load_sel == TGT_IMEM) imem[load_addr[IMEM_AW-1:0]] <= load_data;
    end

    assign fetch_ir = imem[pc_q[IMEM_AW+1:2]];

    // Fetch-to-decode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ifid_vld <= 1'b0;
            ifid_ir  <= '0;
        end else begin
            ifid_vld <= 1'b1;
            ifid_ir  <= fetch_ir;
        end
    end

    // ---------------- decode ----------------
    pipe5_regfile #(.NENT(NREG)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rf_we),
        .wr_idx   (rf_widx),
        .wr_val   (rf_wval),
        .rd_idx_a (ifid_ir[25:21]),
        .rd_val_a (rs_val),
        .rd_idx_b (ifid_ir[20:16]),
        .rd_val_b (rt_val),
        .rd_idx_c (peek_addr[RIDX_W-1:0]),
        .rd_val_c (peek_reg)
    );

    // Decode-to-execute register.
    always_ff @(posedge clk) begin
        if (!rst_n) idex_q <= '0;
        else        idex_q <= '{vld: ifid_vld, ir: ifid_ir, opa: rs_val, opb: rt_val};
    end

    // ---------------- execute ----------------
    pipe5_alu i_alu (
        .opc   (f_opc(idex_q.ir)),
        .funct (idex_q.ir[5:0]),
        .imm   (idex_q.ir[15:0]),
        .opa   (idex_q.opa),
        .opb   (idex_q.opb),
        .res   (alu_res)
    );

    // Execute-to-memory register.
    always_ff @(posedge clk) begin
        if (!rst_n) exmem_q <= '0;
        else        exmem_q <= '{vld: idex_q.vld, ir: idex_q.ir, res: alu_res, sdata: idex_q.opb};
    end

    // ---------------- memory ----------------
    // Data memory: preload port has priority over a store in flight.
    always_ff @(posedge clk) begin
        if (load_en && load_sel == TGT_DMEM)
            dmem[load_addr[DMEM_AW-1:0]] <= load_data;
        else if (f_opc(exmem_q.ir) == OPC_STOR)
            dmem[exmem_q.res[DMEM_AW+1:2]] <= exmem_q.sdata;
    end

    assign mem_rd = dmem[exmem_q.res[DMEM_AW+1:2]];

    // Memory-to-write-back register.
    always_ff @(posedge clk) begin
        if (!rst_n) memwb_q <= '0;
        else        memwb_q <= '{vld: exmem_q.vld, ir: exmem_q.ir, res: exmem_q.res, ldata: mem_rd};
    end

    // ---------------- write-back ----------------
    pipe5_wbsel i_wbsel (
        .opc      (f_opc(memwb_q.ir)),
        .funct    (memwb_q.ir[5:0]),
        .f_rt     (memwb_q.ir[20:16]),
        .f_rd     (memwb_q.ir[15:11]),
        .we       (wb_we),
        .dest     (wb_dest),
        .from_mem (wb_from_mem)
    );

    assign wb_val = wb_from_mem ? memwb_q.ldata : memwb_q.res;

    // Register write port shared by preload and write-back; preload wins.
    always_comb begin
        if (load_en && load_sel == TGT_REGS) begin
            rf_we   = 1'b1;
            rf_widx = load_addr[RIDX_W-1:0];
            rf_wval = load_data;
        end else begin
            rf_we   = wb_we;
            rf_widx = wb_dest;
            rf_wval = wb_val;
        end
    end

    // ---------------- observation ----------------
    // Read-back mux and per-stage occupancy view.
    always_comb begin
        peek_data = peek_sel ? dmem[peek_addr[DMEM_AW-1:0]] : peek_reg;
        stage_vld = {memwb_q.vld, exmem_q.vld, idex_q.vld, ifid_vld, rst_n};
        stage_ir  = {memwb_q.ir, exmem_q.ir, idex_q.ir, ifid_ir, fetch_ir};
    end

    // ---------------- assertions ----------------
    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (ifid_ir == '0 && !ifid_vld && idex_q == '0 &&
                    exmem_q == '0 && memwb_q == '0 && pc_q == '0));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (pc_q == $past(pc_q) + 32'd4));

    // R2
    stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (exmem_q.ir == $past(idex_q.ir) && memwb_q.ir == $past(exmem_q.ir)));

    // R3
    slt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_opc(idex_q.ir) == OPC_REG && idex_q.ir[5:0] == FN_SLT) |-> (alu_res[31:1] == '0));

    // R3
    reg_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && f_opc(memwb_q.ir) == OPC_REG) |-> (wb_dest == memwb_q.ir[15:11]));

    // R4
    imm_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && f_opc(memwb_q.ir) != OPC_REG) |-> (wb_dest == memwb_q.ir[20:16]));

    // R5
    store_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_opc(memwb_q.ir) == OPC_STOR) |-> !wb_we);

    // R8
    unsup_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_opc(memwb_q.ir) != OPC_REG && f_opc(memwb_q.ir) != OPC_ADDI &&
         f_opc(memwb_q.ir) != OPC_LOAD) |-> !wb_we);

endmodule

// File: tb/test_pipe5_core.sv
`timescale 1ns/1ps
module test_pipe5_core;

    localparam int AW = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           load_en = 1'b0;
    logic [1:0]     load_sel = 2'd3;
    logic [AW-1:0]  load_addr = '0;
    logic [31:0]    load_data = '0;
    logic           peek_sel = 1'b0;
    logic [AW-1:0]  peek_addr = '0;
    logic [31:0]    peek_data;
    logic [4:0]     stage_vld;
    logic [159:0]   stage_ir;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    logic [31:0] prog [64];
    logic [31:0] vals [8];

    always #2.5 clk = ~clk;

    pipe5_core #(.IMEM_AW(AW), .DMEM_AW(AW), .LOAD_AW(AW)) i_pipe5_core (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_sel(load_sel),
        .load_addr(load_addr), .load_data(load_data), .peek_sel(peek_sel),
        .peek_addr(peek_addr), .peek_data(peek_data),
        .stage_vld(stage_vld), .stage_ir(stage_ir)
    );

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic load(input logic [1:0] sel, input int addr, input logic [31:0] d);
        @(negedge clk);
        load_en = 1'b1; load_sel = sel; load_addr = addr[AW-1:0]; load_data = d;
        @(negedge clk);
        load_en = 1'b0; load_sel = 2'd3;
    endtask

    task automatic put_prog();
        for (int i = 0; i < 64; i++) load(2'd0, i, prog[i]);
    endtask

    task automatic clr_prog();
        for (int i = 0; i < 64; i++) prog[i] = 32'h0;
    endtask

    task automatic peek(input logic s, input int a, output logic [31:0] v);
        peek_sel = s; peek_addr = a[AW-1:0];
        #1 v = peek_data;
    endtask

    // Release reset for n cycles, optionally checking the occupancy view, then re-enter reset.
    task automatic run(input int n, input bit occ);
        @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < n; j++) begin
            #1;
            if (occ && j < 8) begin
                for (int s = 0; s < 5; s++) begin
                    int idx;
                    idx = j - s;
                    // R2: slot s holds the word fetched s cycles earlier
                    check("R2 vld", {31'd0, stage_vld[s]}, {31'd0, (idx >= 0)});
                    if (idx >= 0) check("R2 word", stage_ir[32*s +: 32], prog[idx]);
                end
            end
            @(negedge clk);
        end
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        vals[0] = 32'h0;        vals[1] = 32'h1;        vals[2] = 32'h7;
        vals[3] = 32'hFFFFFFFF; vals[4] = 32'h7FFFFFFF; vals[5] = 32'h80000000;
        vals[6] = 32'h12345678; vals[7] = 32'hFFFFFFFB;

        repeat (3) @(negedge clk);
        // R1: reset state
        #1;
        check("R1 vld", {27'd0, stage_vld}, 32'd0);
        check("R1 ir", stage_ir[63:32] | stage_ir[95:64] | stage_ir[127:96] | stage_ir[159:128], 32'd0);

        // R3 / R4: sweep operand pairs through all ALU operations
        clr_prog();
        prog[0] = enc_r(6'h20, 3, 1, 2);
        prog[1] = enc_r(6'h22, 4, 1, 2);
        prog[2] = enc_r(6'h24, 5, 1, 2);
        prog[3] = enc_r(6'h25, 6, 1, 2);
        prog[4] = enc_r(6'h2A, 7, 1, 2);
        put_prog();
        for (int ia = 0; ia < 8; ia++) begin
            for (int ib = 0; ib < 8; ib++) begin
                logic [31:0] a, b;
                a = vals[ia]; b = vals[ib];
                load(2'd0, 5, enc_i(6'h08, 8, 1, b[15:0]));
                load(2'd2, 1, a);
                load(2'd2, 2, b);
                run(12, 1'b0);
                peek(1'b0, 3, v); check("R3 add", v, a + b);
                peek(1'b0, 4, v); check("R3 sub", v, a - b);
                peek(1'b0, 5, v); check("R3 and", v, a & b);
                peek(1'b0, 6, v); check("R3 or", v, a | b);
                peek(1'b0, 7, v); check("R3 slt", v, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
                peek(1'b0, 8, v); check("R4 addi", v, a + sx(b[15:0]));
            end
        end

        // R5: store then loads, negative offset and address wrap past depth
        for (int i = 0; i < 64; i++) load(2'd1, i, 32'hD0000000 + i);
        load(2'd2, 10, 32'd40);
        load(2'd2, 11, 32'hCAFEF00D);
        load(2'd2, 14, 32'h00001414);
        clr_prog();
        prog[0] = enc_i(6'h2B, 11, 10, 16'h0008);
        prog[1] = enc_i(6'h23, 12, 10, 16'hFFFC);
        prog[2] = enc_i(6'h23, 13, 10, 16'h0008);
        prog[3] = enc_i(6'h2B, 11, 0, 16'h7000);
        put_prog();
        run(12, 1'b0);
        peek(1'b1, 12, v); check("R5 store word", v, 32'hCAFEF00D);
        peek(1'b0, 12, v); check("R5 load neg offset", v, 32'hD0000009);
        peek(1'b0, 13, v); check("R5 load after store", v, 32'hCAFEF00D);
        peek(1'b1, 0, v);  check("R5 wrapped store", v, 32'hCAFEF00D);
        peek(1'b0, 14, v); check("R5 store writes no reg", v, 32'h00001414);
        peek(1'b0, 11, v); check("R5 store rt kept", v, 32'hCAFEF00D);
        peek(1'b1, 13, v); check("R9 untouched data", v, 32'hD000000D);

        // R7 / R2: stale reads at distance 1 and 2, fresh at 3, with occupancy trace
        load(2'd2, 1, 32'd100);
        clr_prog();
        prog[0] = enc_i(6'h08, 1, 0, 16'd5);
        prog[1] = enc_r(6'h20, 2, 1, 0);
        prog[2] = enc_r(6'h20, 3, 1, 0);
        prog[3] = enc_r(6'h20, 4, 1, 0);
        put_prog();
        run(12, 1'b1);
        peek(1'b0, 1, v); check("R7 producer", v, 32'd5);
        peek(1'b0, 2, v); check("R7 distance 1 stale", v, 32'd100);
        peek(1'b0, 3, v); check("R7 distance 2 stale", v, 32'd100);
        peek(1'b0, 4, v); check("R7 distance 3 fresh", v, 32'd5);

        // R6: register 0 ignores pipeline and preload writes
        load(2'd2, 0, 32'hFFFF0000);
        load(2'd2, 1, 32'd3);
        load(2'd2, 2, 32'd4);
        clr_prog();
        prog[0] = enc_r(6'h20, 0, 1, 2);
        prog[3] = enc_r(6'h20, 5, 0, 1);
        put_prog();
        run(12, 1'b0);
        peek(1'b0, 0, v); check("R6 r0 zero", v, 32'd0);
        peek(1'b0, 5, v); check("R6 r0 operand zero", v, 32'd3);

        // R8: unsupported opcodes and funct write nothing
        load(2'd2, 11, 32'h11111111);
        load(2'd2, 12, 32'h22222222);
        load(2'd2, 13, 32'h33333333);
        load(2'd1, 20, 32'h55555555);
        clr_prog();
        prog[0] = enc_i(6'h3F, 11, 1, 16'h5800);
        prog[1] = enc_r(6'h27, 12, 1, 2);
        prog[2] = enc_i(6'h0D, 13, 0, 16'h0050);
        put_prog();
        run(12, 1'b0);
        peek(1'b0, 11, v); check("R8 bad opcode", v, 32'h11111111);
        peek(1'b0, 12, v); check("R8 bad funct", v, 32'h22222222);
        peek(1'b0, 13, v); check("R8 other opcode", v, 32'h33333333);
        peek(1'b1, 20, v); check("R8 no data write", v, 32'h55555555);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule